// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer that counts against an external free-running system count. Software programs a timeout offset and sets an enable bit. After that it must touch the refresh frame often enough. If the timer is enabled and one offset period passes with no refresh, the first stage fires. It raises a level interrupt and starts a second period of the same length. If that second period also passes with no refresh, the second stage fires and raises a reset request. The reset request stays asserted until the timer is disabled or the block is reset.

Register access uses a simple bus with two select inputs, one for each frame.

- **Control frame.** It holds the control/status word, the offset, and a read-only view of the compare value.
- **Refresh frame.** Any write to this frame restarts the period, whatever the address or data. Reads from it return zero.

A parameter sets the offset width: 32 bits for the basic revision, or 48 bits for the extended one. A 48-bit offset is written as two 32-bit words.

Top module: `wdog_twostage`

## Requirements
- R1: After reset, the enable bit, both stage bits, the offset and the compare value are zero, and `irq_o` and `rst_req_o` are low.
- R2: The control frame holds the offset as follows.
  - Word 1 holds offset bits [31:0].
  - Word 2 holds offset bits [OFS_W-1:32], and the unused upper bits read as zero. For example, writing 0xFFFFFFFF to word 2 with OFS_W=48 reads back as 0x0000FFFF.
- R3: Control word 0 has these fields.
  - Bit 0 is the enable bit and is read/write.
  - Bit 1 is the first-stage status bit and is read-only.
  - Bit 2 is the second-stage status bit and is read-only.
  - All other bits read as zero.
- R4: The compare value is captured as system count plus offset, using the offset value after the write. It is captured on any of these events:
  - a refresh write;
  - an offset write while enabled;
  - a write of 1 to the enable bit while the timer is disabled.

  The compare value reads back at word 3 (bits 31:0) and word 4 (bits 63:32). Writes to words 3 and 4 are ignored.
- R5: The first stage fires on a clock edge where all of these hold: the timer is enabled, the first-stage bit is clear, and the system count is greater than or equal to the compare value. At that edge the first-stage bit and `irq_o` go high, and the compare value reloads to system count plus offset.
- R6: The second stage fires on a clock edge where the first-stage bit is set, the second-stage bit is clear, and the system count is greater than or equal to the compare value. At that edge the second-stage bit and `rst_req_o` go high.
- R7: A write of any data to any address of the refresh frame has these effects at the same edge:
  - both stage bits and `irq_o` clear;
  - the compare value reloads.
- R8: `rst_req_o` stays high through refreshes. Only disabling the timer or resetting the block clears it.
- R9: Clearing the enable bit clears both stage bits, `irq_o` and `rst_req_o` at the same edge. No stage fires while the timer is disabled.
- R10: Read data is registered and valid one cycle after `rd_en`. It is zero for unmapped control addresses, for refresh frame reads, and when no read is requested.
- R11: If a refresh and a compare hit happen at the same edge, the refresh wins: no stage bit is set and the compare value reloads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_sel | input | 1 | Selects the control frame |
| rf_sel | input | 1 | Selects the refresh frame |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address within the selected frame |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| sys_cnt | input | 64 | Free-running system count |
| irq_o | output | 1 | First-stage interrupt (level) |
| rst_req_o | output | 1 | Second-stage reset request (level) |

## Verification
Some states are hard to reach from the ports:
- the second stage needs two expiries in a row with no refresh in between;
- the refresh-versus-hit race only arises when a refresh write lands on the exact edge where the count reaches the compare value.

The bench therefore drives the system count itself, not as a free-running counter. It places the count one below the compare value and then exactly on it. It also moves the count past the compare value in the same cycle as a refresh write. This makes the timing of every stage boundary and the priority rule observable cycle by cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W  = 64;
  localparam int DATA_W = 32;

  // control frame word indices
  localparam logic [2:0] ADR_CTRL   = 3'd0;
  localparam logic [2:0] ADR_OFS_LO = 3'd1;
  localparam logic [2:0] ADR_OFS_HI = 3'd2;
  localparam logic [2:0] ADR_CMP_LO = 3'd3;
  localparam logic [2:0] ADR_CMP_HI = 3'd4;

  // control word bit positions
  localparam int BIT_EN  = 0;
  localparam int BIT_WS0 = 1;
  localparam int BIT_WS1 = 2;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int OFS_W  = 48,
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ctl_sel,
  input  logic                rf_sel,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [CNT_W-1:0]    cmp_i,
  input  logic                ws0_i,
  input  logic                ws1_i,
  output logic                en_nxt_o,
  output logic [OFS_W-1:0]    ofs_nxt_o,
  output logic                reload_o,
  output logic [DATA_W-1:0]   rdata_o
);
  localparam int HI_W = (OFS_W > 32) ? OFS_W - 32 : 1;

  logic              en_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [DATA_W-1:0] rdata_q;
  logic              ctl_wr;
  logic              rf_wr;
  logic              lo_hit;
  logic              hi_hit;
  logic [31:0]       lo_nxt;
  logic [DATA_W-1:0] hi_rd;
  logic              en_nxt;

  assign ctl_wr = ctl_sel & wr_en;
  assign rf_wr  = rf_sel & wr_en;
  assign lo_hit = ctl_wr && (addr == ADDR_W'(ADR_OFS_LO));
  assign lo_nxt = lo_hit ? wdata : ofs_q[31:0];

  generate
    if (OFS_W > 32) begin : g_wide
      logic [HI_W-1:0] hi_nxt;
      assign hi_hit    = ctl_wr && (addr == ADDR_W'(ADR_OFS_HI));
      assign hi_nxt    = hi_hit ? wdata[HI_W-1:0] : ofs_q[OFS_W-1:32];
      assign ofs_nxt_o = {hi_nxt, lo_nxt};
      assign hi_rd     = {{(DATA_W-HI_W){1'b0}}, ofs_q[OFS_W-1:32]};
    end else begin : g_narrow
      assign hi_hit    = 1'b0;
      assign ofs_nxt_o = lo_nxt;
      assign hi_rd     = '0;
    end
  endgenerate

  assign en_nxt   = (ctl_wr && (addr == ADDR_W'(ADR_CTRL))) ? wdata[BIT_EN] : en_q;
  assign en_nxt_o = en_nxt;
  assign reload_o = rf_wr | (en_q & (lo_hit | hi_hit)) | (en_nxt & ~en_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      ofs_q <= '0;
    end else begin
      en_q  <= en_nxt;
      ofs_q <= ofs_nxt_o;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en && ctl_sel) begin
      case (addr)
        ADDR_W'(ADR_CTRL):   rdata_q <= {{(DATA_W-3){1'b0}}, ws1_i, ws0_i, en_q};
        ADDR_W'(ADR_OFS_LO): rdata_q <= ofs_q[31:0];
        ADDR_W'(ADR_OFS_HI): rdata_q <= hi_rd;
        ADDR_W'(ADR_CMP_LO): rdata_q <= cmp_i[31:0];
        ADDR_W'(ADR_CMP_HI): rdata_q <= cmp_i[CNT_W-1:32];
        default:             rdata_q <= '0;
      endcase
    end else begin
      rdata_q <= '0;
    end
  end

  assign rdata_o = rdata_q;

  // R10
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rdata_o == '0);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int OFS_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             reload,
  input  logic [OFS_W-1:0] ofs,
  input  logic [CNT_W-1:0] sys_cnt,
  output logic [CNT_W-1:0] cmp_o,
  output logic             ws0_o,
  output logic             ws1_o,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] cmp_nxt;
  logic             ws0_q, ws1_q, rreq_q;
  logic             hit;

  assign cmp_nxt = sys_cnt + CNT_W'(ofs);
  assign hit     = sys_cnt >= cmp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      ws0_q  <= 1'b0;
      ws1_q  <= 1'b0;
      rreq_q <= 1'b0;
    end else if (!en) begin
      ws0_q  <= 1'b0;
      ws1_q  <= 1'b0;
      rreq_q <= 1'b0;
    end else if (reload) begin
      cmp_q <= cmp_nxt;
      ws0_q <= 1'b0;
      ws1_q <= 1'b0;
    end else if (hit && !ws0_q) begin
      ws0_q <= 1'b1;
      cmp_q <= cmp_nxt;
    end else if (hit && !ws1_q) begin
      ws1_q  <= 1'b1;
      rreq_q <= 1'b1;
    end
  end

  assign cmp_o     = cmp_q;
  assign ws0_o     = ws0_q;
  assign ws1_o     = ws1_q;
  assign rst_req_o = rreq_q;

  // R5
  stage1_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ws0_q) |-> $past(en) && $past(hit));
  // R6
  stage2_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ws1_q) |-> $past(ws0_q));
  // R7
  refresh_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (reload && en) |=> !ws0_q && !ws1_q);
  // R8
  rreq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rreq_q && en) |=> rreq_q);
  // R9
  disable_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !ws0_q && !ws1_q && !rreq_q);
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
  import wdog_pkg::*;
#(
  parameter int OFS_W  = 48,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_sel,
  input  logic              rf_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [63:0]       sys_cnt,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic             en_nxt;
  logic             reload;
  logic [OFS_W-1:0] ofs_nxt;
  logic [CNT_W-1:0] cmp;
  logic             ws0, ws1;

  wdog_regs #(.OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .ctl_sel(ctl_sel), .rf_sel(rf_sel),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .cmp_i(cmp), .ws0_i(ws0), .ws1_i(ws1),
    .en_nxt_o(en_nxt), .ofs_nxt_o(ofs_nxt), .reload_o(reload),
    .rdata_o(rdata)
  );

  wdog_timer #(.OFS_W(OFS_W)) u_timer (
    .clk(clk), .rst(rst), .en(en_nxt), .reload(reload), .ofs(ofs_nxt),
    .sys_cnt(sys_cnt), .cmp_o(cmp), .ws0_o(ws0), .ws1_o(ws1),
    .rst_req_o(rst_req_o)
  );

  assign irq_o = ws0;
endmodule

// File: tb/test_wdog_twostage.sv
`timescale 1ns/1ps
module test_wdog_twostage;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_sel = 1'b0, rf_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] sys_cnt = '0;
  logic        irq_o, rst_req_o;
  int          n_chk = 0, n_err = 0, cyc = 0;
  logic [31:0] v;

  always #2.5 clk = ~clk;

  wdog_twostage #(.OFS_W(48), .ADDR_W(3)) i_wdog_twostage (
    .clk(clk), .rst(rst), .ctl_sel(ctl_sel), .rf_sel(rf_sel), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .sys_cnt(sys_cnt), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired act=%0d exp<=50000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic ctl, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    ctl_sel = ctl; rf_sel = ~ctl; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    ctl_sel = 1'b0; rf_sel = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd(input logic ctl, input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    ctl_sel = ctl; rf_sel = ~ctl; rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    ctl_sel = 1'b0; rf_sel = 1'b0; rd_en = 1'b0;
  endtask

  task automatic set_cnt(input logic [63:0] c);
    @(negedge clk);
    sys_cnt = c;
    @(negedge clk);
  endtask

  // register vectors: write data to a control word, read it back
  localparam int NV = 8;
  localparam logic [2:0]  V_ADR [NV] = '{3'd1, 3'd2, 3'd2, 3'd0, 3'd5, 3'd3, 3'd1, 3'd1};
  localparam logic [31:0] V_DAT [NV] = '{32'h100, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFE,
                                         32'h1234, 32'h5555, 32'hDEAD_BEEF, 32'h100};
  localparam logic [31:0] V_EXP [NV] = '{32'h100, 32'h0000_FFFF, 32'h0, 32'h0,
                                         32'h0, 32'h0, 32'hDEAD_BEEF, 32'h100};
  localparam int          V_REQ [NV] = '{2, 2, 2, 3, 10, 4, 2, 2};

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq", irq_o, 0);
    chk("R1 rst_req", rst_req_o, 0);
    rd(1'b1, 3'd0, v); chk("R1 ctrl", v, 0);
    rd(1'b1, 3'd1, v); chk("R1 ofs", v, 0);
    rd(1'b1, 3'd3, v); chk("R1 cmp", v, 0);

    for (int i = 0; i < NV; i++) begin
      wr(1'b1, V_ADR[i], V_DAT[i]);
      rd(1'b1, V_ADR[i], v);
      chk($sformatf("R%0d vector %0d", V_REQ[i], i), v, V_EXP[i]);
    end
    rd(1'b0, 3'd0, v); chk("R10 refresh frame read", v, 0);

    // R4 enable loads compare
    set_cnt(64'd1000);
    wr(1'b1, 3'd0, 32'h1);
    rd(1'b1, 3'd3, v); chk("R4 cmp on enable", v, 1256);
    rd(1'b1, 3'd0, v); chk("R3 ctrl enabled", v, 1);

    // R5 boundary and first stage
    set_cnt(64'd1255);
    repeat (3) @(negedge clk);
    chk("R5 no fire below cmp", irq_o, 0);
    set_cnt(64'd1256);
    chk("R5 irq", irq_o, 1);
    chk("R5 no rst_req yet", rst_req_o, 0);
    rd(1'b1, 3'd0, v); chk("R5 ctrl ws0", v, 3);
    rd(1'b1, 3'd3, v); chk("R5 cmp reload", v, 1512);

    // R6 second stage
    set_cnt(64'd1511);
    chk("R6 no rst_req below cmp", rst_req_o, 0);
    set_cnt(64'd1512);
    chk("R6 rst_req", rst_req_o, 1);
    rd(1'b1, 3'd0, v); chk("R6 ctrl ws1", v, 7);

    // R7 refresh, R8 reset request held
    wr(1'b0, 3'd5, 32'hFFFF_FFFF);
    chk("R7 irq cleared", irq_o, 0);
    chk("R8 rst_req held", rst_req_o, 1);
    rd(1'b1, 3'd0, v); chk("R7 ctrl after refresh", v, 1);
    rd(1'b1, 3'd3, v); chk("R7 cmp reload", v, 1768);

    // R9 disable
    wr(1'b1, 3'd0, 32'h0);
    chk("R9 rst_req cleared", rst_req_o, 0);
    chk("R9 irq cleared", irq_o, 0);
    set_cnt(64'd100000);
    repeat (3) @(negedge clk);
    chk("R9 no fire while disabled", irq_o, 0);
    rd(1'b1, 3'd0, v); chk("R9 ctrl", v, 0);

    // R11 refresh wins over hit in the same edge
    wr(1'b1, 3'd0, 32'h1);
    @(negedge clk);
    sys_cnt = 64'd200000; rf_sel = 1'b1; wr_en = 1'b1; addr = 3'd0;
    @(negedge clk);
    rf_sel = 1'b0; wr_en = 1'b0;
    chk("R11 irq stays low", irq_o, 0);
    rd(1'b1, 3'd3, v); chk("R11 cmp reload", v, 200256);

    // R4 offset write acts as refresh
    set_cnt(64'd200256);
    chk("R5 irq before offset write", irq_o, 1);
    wr(1'b1, 3'd1, 32'h40);
    chk("R4 offset write clears irq", irq_o, 0);
    rd(1'b1, 3'd3, v); chk("R4 cmp new offset", v, 200320);
    wr(1'b1, 3'd2, 32'h1);
    rd(1'b1, 3'd4, v); chk("R2 R4 cmp high word", v, 1);
    rd(1'b1, 3'd3, v); chk("R4 cmp low word", v, 200320);

    // R1 reset mid-run
    set_cnt(64'h2_0000_0000);
    chk("R5 irq wide compare", irq_o, 1);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    chk("R1 irq after reset", irq_o, 0);
    rd(1'b1, 3'd0, v); chk("R1 ctrl after reset", v, 0);
    rd(1'b1, 3'd2, v); chk("R1 ofs high after reset", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule